// File: doc/BRIEF.md
# Step-wise Hamming parity generator for NAND page data

This block computes single-error-correcting Hamming parity over a byte stream in fixed steps of 256 bytes. Each accepted byte adds to two running accumulators. The column accumulator tracks the parity of groups of bit positions inside a byte. The line accumulator tracks the parity of whole bytes, grouped by the bits of the byte's index within the step. When a step completes, the two results are merged into a raw parity word. A packed 24-bit code is derived from that word in the form the spare area stores.

A page is streamed as consecutive steps. The block keeps one raw word for each completed step in a small capture array, up to a parameterised number of steps. The array can be read back by step number. A clear pulse starts a new page: it discards any partial step, the captured words and the step count.

Top module: `ecc256_gen`

## Requirements
- R1: While reset is held and right after it, `raw_o` is 0, `code_o` is 24'hFFFFFF, `step_done_o` is 0, `steps_o` is 0 and `rd_word_o` reads 0 for every `rd_sel_i`.
- R2: Raw bits 5:0 hold column parity. For j = 0..2, bit 2j+1 is the XOR of every accepted data bit whose bit position has bit j set. Bit 2j is the same XOR over the positions where bit j is clear.
- R3: Raw bits 20:6 hold line parity, and bits 31:21 are 0. Let p(i) be the XOR of the 8 bits of the byte at index i (0..255) within the step. For k = 0..6, bit 7+2k is the XOR of p(i) over all i with index bit k set, and bit 6+2k is the same over i with index bit k clear. Bit 20 is the XOR of p(i) over all i with index bit 7 set.
- R4: `code_o` equals the bitwise inverse of (`raw_o` shifted left by two), kept to its low 24 bits. The byte stored first is `code_o[23:16]`, then `[15:8]`, then `[7:0]`.
- R5: `step_done_o` is high for exactly one cycle, in the cycle after the clock edge that accepts the 256th valid byte of a step. `raw_o` shows that step's word in the same cycle.
- R6: `raw_o` changes only when a step completes or when a clear is applied. Bytes of a step still in progress leave it unchanged.
- R7: A cycle with `vld_i` low is ignored. It neither adds its byte nor advances the byte index, so gaps inside a step leave the step's result unchanged.
- R8: A cycle with `clr_i` high takes priority over `vld_i`. From the next cycle on, `raw_o`, `steps_o` and every captured word are 0, and the byte index restarts at 0, so any partial step is discarded.
- R9: The accumulators restart from zero after each step, so the word of a step depends only on that step's 256 bytes.
- R10: The word of the n-th completed step since the last clear (counted from 0) is readable at `rd_word_o` with `rd_sel_i` = n. `steps_o` counts completed steps and stops at MAX_STEPS (16). Steps beyond that still update `raw_o` and pulse `step_done_o`, but they are not captured.
- R11: If two steps differ in exactly one data bit, at byte index i and bit position b, then XOR their raw words. The odd-numbered line bits 7,9,...,19 and bit 20 then spell i (LSB first), and the column bits 1,3,5 spell b.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| clr_i | input | 1 | Start-of-page clear, one cycle, wins over vld_i |
| vld_i | input | 1 | byte_i carries a data byte this cycle |
| byte_i | input | 8 | Data byte |
| raw_o | output | 32 | Raw parity word of the latest completed step |
| code_o | output | 24 | Packed storage code, first stored byte in bits 23:16 |
| step_done_o | output | 1 | One-cycle pulse when a step completes |
| steps_o | output | 5 | Completed steps since the last clear, saturating |
| rd_sel_i | input | 4 | Step number to read from the capture array |
| rd_word_o | output | 32 | Captured raw word of step rd_sel_i |

## Verification
The step result, the done pulse and the step count all become visible in the cycle after the edge that accepts a step's 256th valid byte. A clear is visible in the cycle after the edge that samples it. `code_o` and `rd_word_o` follow `raw_o` and `rd_sel_i` within the same cycle, with no register between them. The bench's reference model advances at each rising edge. The bench compares all outputs one nanosecond after that edge, so every comparison falls on the cycle in which the result is due. Read selects change only on the falling edge.

// File: rtl/ecc256_pkg.sv
// Shared constants and helpers for the step-wise Hamming parity generator.
// Assumes byte-wide data; column parity needs two bits per bit-select line.
package ecc256_pkg;
    localparam int BYTE_W   = 8;
    localparam int BITSEL_W = $clog2(BYTE_W);
    localparam int COL_W    = 2 * BITSEL_W;
    localparam int CODE_W   = 24;
    localparam int WORD_W   = 32;
    localparam int SHIFT    = 2;
endpackage

// File: rtl/ecc256_col_acc.sv
// Column parity accumulator: folds each accepted byte into 2*log2(8) parity
// bits (odd bit: positions with select bit set; even bit: positions with it
// clear). Assumes restart has priority over enable.
module ecc256_col_acc
    import ecc256_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart_i,
    input  logic              en_i,
    input  logic [BYTE_W-1:0] din_i,
    output logic [COL_W-1:0]  nxt_o
);
    logic [COL_W-1:0] acc_q;
    logic [COL_W-1:0] contrib;

    // Per-byte column contribution, one pair of bits per bit-select line.
    always_comb begin
        contrib = '0;
        for (int j = 0; j < BITSEL_W; j++) begin
            for (int b = 0; b < BYTE_W; b++) begin
                if (((b >> j) & 1) == 1)
                    contrib[2*j+1] = contrib[2*j+1] ^ din_i[b];
                else
                    contrib[2*j]   = contrib[2*j] ^ din_i[b];
            end
        end
    end

    // Accumulated value including the byte of this cycle.
    assign nxt_o = en_i ? (acc_q ^ contrib) : acc_q;

    // Running column parity, zeroed at step or page start.
    always_ff @(posedge clk) begin
        if (!rst_n)         acc_q <= '0;
        else if (restart_i) acc_q <= '0;
        else if (en_i)      acc_q <= nxt_o;
    end
endmodule

// File: rtl/ecc256_line_acc.sv
// Line parity accumulator: the parity of each byte is steered into the
// "set" or "clear" bit of every byte-index line. The top index line keeps
// only its "set" half. Assumes idx_i is the byte's position within the step.
module ecc256_line_acc
    import ecc256_pkg::*;
#(
    parameter int IDX_W  = 8,
    localparam int LINE_W = 2 * IDX_W - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart_i,
    input  logic              en_i,
    input  logic [BYTE_W-1:0] din_i,
    input  logic [IDX_W-1:0]  idx_i,
    output logic [LINE_W-1:0] nxt_o
);
    logic [LINE_W-1:0] acc_q;
    logic [LINE_W-1:0] contrib;
    logic              bpar;

    // Parity of the whole byte.
    assign bpar = ^din_i;

    // Steer the byte parity into one bit of each index-line pair.
    for (genvar k = 0; k < IDX_W - 1; k++) begin : g_pair
        assign contrib[2*k]   = bpar & ~idx_i[k];
        assign contrib[2*k+1] = bpar &  idx_i[k];
    end
    assign contrib[LINE_W-1] = bpar & idx_i[IDX_W-1];

    // Accumulated value including the byte of this cycle.
    assign nxt_o = en_i ? (acc_q ^ contrib) : acc_q;

    // Running line parity, zeroed at step or page start.
    always_ff @(posedge clk) begin
        if (!rst_n)         acc_q <= '0;
        else if (restart_i) acc_q <= '0;
        else if (en_i)      acc_q <= nxt_o;
    end
endmodule

// File: rtl/ecc256_code_pack.sv
// Storage-code packer: shifts the raw word left by two, inverts it and keeps
// CODE_W bits. Purely combinational; the first stored byte is the top byte.
module ecc256_code_pack
    import ecc256_pkg::*;
(
    input  logic [CODE_W-SHIFT-1:0] raw_i,
    output logic [CODE_W-1:0]       code_o
);
    // Shift, invert, truncate.
    assign code_o = ~{raw_i, {SHIFT{1'b0}}};
endmodule

// File: rtl/ecc256_step_store.sv
// Capture array with one raw word per completed step and a combinational
// read port. Assumes DEPTH >= 2 and wsel_i < DEPTH whenever we_i is high.
module ecc256_step_store #(
    parameter int DEPTH = 16,
    parameter int W     = 32,
    localparam int SEL_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             we_i,
    input  logic [SEL_W-1:0] wsel_i,
    input  logic [W-1:0]     wdata_i,
    input  logic [SEL_W-1:0] rsel_i,
    output logic [W-1:0]     rdata_o
);
    logic [W-1:0] mem [DEPTH];

    // One register per step slot, cleared with the page.
    for (genvar s = 0; s < DEPTH; s++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n)                              mem[s] <= '0;
            else if (clr_i)                          mem[s] <= '0;
            else if (we_i && wsel_i == SEL_W'(s))    mem[s] <= wdata_i;
        end
    end

    // Read port.
    assign rdata_o = mem[rsel_i];
endmodule

// File: rtl/ecc256_gen.sv
// Step-wise Hamming parity generator. It counts valid bytes within a
// STEP_BYTES step, merges column and line parity into a raw word at step
// end, packs the storage code and captures one word per step. Assumes
// STEP_BYTES is a power of two with 2*log2(STEP_BYTES)-1+6 <= 22 bits of
// parity, and MAX_STEPS >= 2. Clear wins over valid.
module ecc256_gen
    import ecc256_pkg::*;
#(
    parameter int STEP_BYTES = 256,
    parameter int MAX_STEPS  = 16,
    localparam int IDX_W  = $clog2(STEP_BYTES),
    localparam int LINE_W = 2 * IDX_W - 1,
    localparam int RAW_W  = COL_W + LINE_W,
    localparam int CNT_W  = $clog2(MAX_STEPS + 1),
    localparam int SEL_W  = $clog2(MAX_STEPS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              vld_i,
    input  logic [BYTE_W-1:0] byte_i,
    output logic [WORD_W-1:0] raw_o,
    output logic [CODE_W-1:0] code_o,
    output logic              step_done_o,
    output logic [CNT_W-1:0]  steps_o,
    input  logic [SEL_W-1:0]  rd_sel_i,
    output logic [WORD_W-1:0] rd_word_o
);
    logic [IDX_W-1:0]  idx_q;
    logic [CNT_W-1:0]  steps_q;
    logic [WORD_W-1:0] raw_q;
    logic              done_q;
    logic              accept, last, restart, room;
    logic [COL_W-1:0]  col_nxt;
    logic [LINE_W-1:0] line_nxt;
    logic [WORD_W-1:0] step_word;

    // Byte acceptance and step-end detection.
    assign accept  = vld_i & ~clr_i;
    assign last    = accept && (idx_q == IDX_W'(STEP_BYTES - 1));
    assign restart = clr_i | last;
    assign room    = steps_q < CNT_W'(MAX_STEPS);

    ecc256_col_acc u_col (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (restart),
        .en_i      (accept),
        .din_i     (byte_i),
        .nxt_o     (col_nxt)
    );

    ecc256_line_acc #(.IDX_W(IDX_W)) u_line (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (restart),
        .en_i      (accept),
        .din_i     (byte_i),
        .idx_i     (idx_q),
        .nxt_o     (line_nxt)
    );

    // Merge line parity above column parity, zero-extended to the word.
    assign step_word = WORD_W'({line_nxt, col_nxt});

    // Byte index within the current step.
    always_ff @(posedge clk) begin
        if (!rst_n)      idx_q <= '0;
        else if (clr_i)  idx_q <= '0;
        else if (last)   idx_q <= '0;
        else if (accept) idx_q <= idx_q + 1'b1;
    end

    // Step-end pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) done_q <= 1'b0;
        else        done_q <= last;
    end

    // Raw word of the latest completed step.
    always_ff @(posedge clk) begin
        if (!rst_n)     raw_q <= '0;
        else if (clr_i) raw_q <= '0;
        else if (last)  raw_q <= step_word;
    end

    // Saturating count of completed steps.
    always_ff @(posedge clk) begin
        if (!rst_n)             steps_q <= '0;
        else if (clr_i)         steps_q <= '0;
        else if (last && room)  steps_q <= steps_q + 1'b1;
    end

    ecc256_step_store #(.DEPTH(MAX_STEPS), .W(WORD_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (clr_i),
        .we_i    (last && room),
        .wsel_i  (steps_q[SEL_W-1:0]),
        .wdata_i (step_word),
        .rsel_i  (rd_sel_i),
        .rdata_o (rd_word_o)
    );

    ecc256_code_pack u_pack (
        .raw_i  (raw_q[CODE_W-SHIFT-1:0]),
        .code_o (code_o)
    );

    assign raw_o       = raw_q;
    assign step_done_o = done_q;
    assign steps_o     = steps_q;
endmodule

// File: rtl/ecc256_gen_chk.sv
// Protocol checker for ecc256_gen: watches ports over time, attached by bind.
module ecc256_gen_chk #(
    parameter int MAX_STEPS = 16,
    parameter int CNT_W     = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             clr_i,
    input logic             vld_i,
    input logic [31:0]      raw_o,
    input logic             step_done_o,
    input logic [CNT_W-1:0] steps_o,
    input logic [31:0]      rd_word_o
);
    // Done never lasts two cycles.
    assert_done_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        step_done_o |=> !step_done_o);

    // Raw word moves only at step end or after a clear.
    assert_raw_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!step_done_o && !$past(clr_i)) |-> $stable(raw_o));

    // A cycle without a valid byte cannot finish a step.
    assert_idle_no_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!vld_i || clr_i) |=> !step_done_o);

    // A clear empties the result, count and capture port.
    assert_clear_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(clr_i) |-> (raw_o == 32'd0 && steps_o == '0 && !step_done_o && rd_word_o == 32'd0));

    // Count never passes its limit.
    assert_count_cap_R10: assert property (@(posedge clk) disable iff (!rst_n)
        steps_o <= CNT_W'(MAX_STEPS));

    // Count steps up by one with each captured step.
    assert_count_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (step_done_o && $past(steps_o) < CNT_W'(MAX_STEPS)) |-> steps_o == $past(steps_o) + 1'b1);

    // Count holds when no step ends and no clear was seen.
    assert_count_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!step_done_o && !$past(clr_i)) |-> $stable(steps_o));
endmodule

bind ecc256_gen ecc256_gen_chk #(.MAX_STEPS(MAX_STEPS), .CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .clr_i       (clr_i),
    .vld_i       (vld_i),
    .raw_o       (raw_o),
    .step_done_o (step_done_o),
    .steps_o     (steps_o),
    .rd_word_o   (rd_word_o)
);

// File: tb/sim_ecc256_gen.sv
// Bench for ecc256_gen: behavioural reference model compared every cycle,
// plus directed checks per requirement.
module sim_ecc256_gen;
    localparam int STEP = 256;
    localparam int MAXS = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clr = 1'b0;
    logic        vld = 1'b0;
    logic [7:0]  din = 8'h00;
    logic [3:0]  rd_sel = 4'd0;
    logic [31:0] raw, rd_word;
    logic [23:0] code;
    logic        done;
    logic [4:0]  steps;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    ecc256_gen u0 (
        .clk(clk), .rst_n(rst_n), .clr_i(clr), .vld_i(vld), .byte_i(din),
        .raw_o(raw), .code_o(code), .step_done_o(done), .steps_o(steps),
        .rd_sel_i(rd_sel), .rd_word_o(rd_word)
    );

    // Expected raw word of one step, computed bit by bit from R2 and R3.
    function automatic logic [31:0] ref_word(input logic [7:0] a [STEP]);
        logic [31:0] r = '0;
        for (int i = 0; i < STEP; i++) begin
            for (int b = 0; b < 8; b++) begin
                if (a[i][b]) begin
                    for (int j = 0; j < 3; j++)
                        if (((b >> j) & 1) == 1) r[2*j+1] = ~r[2*j+1];
                        else                     r[2*j]   = ~r[2*j];
                    for (int k = 0; k < 8; k++) begin
                        if (k < 7) begin
                            if (((i >> k) & 1) == 1) r[7+2*k] = ~r[7+2*k];
                            else                     r[6+2*k] = ~r[6+2*k];
                        end else if (((i >> 7) & 1) == 1) begin
                            r[20] = ~r[20];
                        end
                    end
                end
            end
        end
        return r;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Reference model state.
    logic [31:0] m_raw;
    logic        m_done;
    int          m_steps;
    logic [31:0] m_store [MAXS];
    logic [7:0]  m_q [$];

    // Model: advances on each rising edge from the driven inputs.
    always @(posedge clk) begin
        if (!rst_n || clr) begin
            m_raw = '0; m_done = 0; m_steps = 0; m_q.delete();
            foreach (m_store[s]) m_store[s] = '0;
        end else begin
            m_done = 0;
            if (vld) begin
                m_q.push_back(din);
                if (m_q.size() == STEP) begin
                    logic [7:0] tmp [STEP];
                    foreach (tmp[i]) tmp[i] = m_q[i];
                    m_raw = ref_word(tmp);
                    m_done = 1;
                    if (m_steps < MAXS) begin
                        m_store[m_steps] = m_raw;
                        m_steps++;
                    end
                    m_q.delete();
                end
            end
        end
    end

    // Per-cycle comparison, 1 ns after the rising edge.
    always @(posedge clk) begin
        #1;
        if (rst_n && !finished) begin
            chk("R5 done", {31'd0, done}, {31'd0, m_done});
            chk("R6 raw", raw, m_raw);
            chk("R4 code", {8'd0, code}, {8'd0, (~(m_raw << 2)) & 32'h00FF_FFFF});
            chk("R10 steps", {27'd0, steps}, 32'(m_steps));
            chk("R10 rdword", rd_word, m_store[rd_sel]);
        end
    end

    logic [7:0] blk [STEP];

    task automatic send_byte(input logic [7:0] b);
        @(negedge clk); vld = 1'b1; din = b;
    endtask

    task automatic gap_cycle();
        @(negedge clk); vld = 1'b0; din = 8'hFF;
    endtask

    // Streams blk as one step; returns 1 ns after the accepting edge.
    task automatic run_step(input bit gaps);
        for (int i = 0; i < STEP; i++) begin
            if (gaps && (i % 3 == 1)) gap_cycle();
            send_byte(blk[i]);
        end
        @(posedge clk); #1;
        vld = 1'b0;
    endtask

    task automatic do_clear();
        @(negedge clk); clr = 1'b1; vld = 1'b1; din = 8'h5A;
        @(negedge clk); clr = 1'b0; vld = 1'b0;
    endtask

    task automatic fill(input int seed);
        for (int i = 0; i < STEP; i++) blk[i] = 8'((i * (seed | 1) + seed * 13) ^ (i >> 3));
    endtask

    initial begin
        logic [31:0] held, ra, rb, d;
        logic [31:0] refs [MAXS + 1];
        logic [7:0] loc_i;
        logic [2:0] loc_b;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk); #1;
        // R1 reset state
        chk("R1 raw", raw, 32'd0);
        chk("R1 code", {8'd0, code}, 32'h00FF_FFFF);
        chk("R1 done", {31'd0, done}, 32'd0);
        chk("R1 steps", {27'd0, steps}, 32'd0);
        chk("R1 rdword", rd_word, 32'd0);

        // R2/R3/R4: one set bit (byte 0, bit 7)
        foreach (blk[i]) blk[i] = 8'h00;
        blk[0] = 8'h80;
        run_step(0);
        chk("R5 done pulse", {31'd0, done}, 32'd1);
        chk("R2 col", {26'd0, raw[5:0]}, 32'h2A);
        chk("R3 word", raw, 32'h0005_556A);
        chk("R4 code", {8'd0, code}, 32'h00EA_AA57);
        chk("R4 first byte", {24'd0, code[23:16]}, 32'hEA);
        @(posedge clk); #1;
        chk("R5 done drop", {31'd0, done}, 32'd0);

        // R3: one set bit (byte 255, bit 0)
        foreach (blk[i]) blk[i] = 8'h00;
        blk[255] = 8'h01;
        run_step(0);
        chk("R3 word", raw, 32'h001A_AA95);
        chk("R2 col", {26'd0, raw[5:0]}, 32'h15);

        // R7: gaps with junk bytes
        fill(7);
        run_step(1);
        chk("R7 gaps", raw, ref_word(blk));

        // R6: partial step leaves raw unchanged
        held = raw;
        for (int i = 0; i < 100; i++) send_byte(8'(i + 3));
        @(posedge clk); #1; vld = 1'b0;
        chk("R6 hold", raw, held);

        // R8: clear discards partial step
        do_clear();
        chk("R8 raw", raw, 32'd0);
        chk("R8 steps", {27'd0, steps}, 32'd0);
        chk("R8 rdword", rd_word, 32'd0);
        fill(21);
        run_step(0);
        chk("R8 fresh step", raw, ref_word(blk));

        // R9: back-to-back step independent of the previous one
        fill(42);
        run_step(0);
        chk("R9 second step", raw, ref_word(blk));

        // R11: single-bit difference locates the bit
        fill(99);
        run_step(0);
        ra = raw;
        blk[8'hA5] = blk[8'hA5] ^ 8'h20;
        run_step(0);
        rb = raw;
        d = ra ^ rb;
        for (int k = 0; k < 7; k++) loc_i[k] = d[7+2*k];
        loc_i[7] = d[20];
        loc_b = {d[5], d[3], d[1]};
        chk("R11 byte index", {24'd0, loc_i}, 32'hA5);
        chk("R11 bit pos", {29'd0, loc_b}, 32'd5);

        // R10: capture and saturation over 17 steps
        do_clear();
        for (int s = 0; s <= MAXS; s++) begin
            fill(s * 5 + 1);
            refs[s] = ref_word(blk);
            run_step(0);
        end
        chk("R10 steps sat", {27'd0, steps}, 32'd16);
        chk("R10 raw after cap", raw, refs[MAXS]);
        for (int s = 0; s < MAXS; s++) begin
            @(negedge clk); rd_sel = 4'(s);
            #1;
            chk("R10 capture", rd_word, refs[s]);
        end

        @(negedge clk);
        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++; bad++;
            $display("FAIL watchdog act=hung exp=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule